// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Indirect and Interrupt Subcycles

This block is the control unit of a small accumulator machine. It steps the machine through its subcycles: it fetches an instruction word through a single memory port, inspects the word, runs an extra memory read to resolve an indirect operand address when the word asks for one, and then executes the operation. At the end of every executed instruction it looks at the interrupt request. If requests are enabled, it pushes the program counter onto a memory stack and redirects execution to a fixed handler address.

The machine registers sit in a small datapath that the sequencer steers cycle by cycle. They are the program counter, instruction register, memory address register, memory buffer register, accumulator, stack pointer and an interrupt-enable flag. The memory address comes straight from the address register and the write data straight from the buffer register. A read or write strobe is held until memory returns ready, so memories with any number of wait states can be attached.

Instruction word (16 bits by default): opcode in bits 15:12, indirect flag in bit 11, address field in bits 10:0. Opcodes: 0 no-op, 1 load, 2 store, 3 add, 4 jump, 5 enable interrupts, 6 disable interrupts, 15 halt. Any other opcode behaves as a no-op.

The states and their transitions are as follows:
- FETCH_A: the address register takes the PC while the PC increments. It goes to FETCH_M.
- FETCH_M: a read is held. On ready the buffer register and the IR capture the word and the state goes to DECODE.
- DECODE: goes to IND_A when the indirect flag is set, otherwise to EXEC_A.
- IND_A: the address register takes the buffer register's low address bits. It goes to IND_M.
- IND_M: a read is held. On ready the buffer register captures the operand address and the state goes to EXEC_A.
- EXEC_A: the address register takes the effective address. The opcode then picks the next state:
  - load and add go to EXEC_RD;
  - store copies the accumulator to the buffer register and goes to EXEC_WR;
  - jump loads the PC, enable and disable set or clear the flag, and these and the no-ops go to CHECK;
  - halt goes to HALT.
- EXEC_RD: a read is held. On ready the accumulator is loaded or added to, and the state goes to CHECK.
- EXEC_WR: a write is held. On ready the state goes to CHECK.
- CHECK: goes to INT_SAVE when a request is present and enabled, otherwise to FETCH_A.
- INT_SAVE: the buffer register takes the PC and the stack pointer decrements. It goes to INT_A.
- INT_A: the address register takes the stack pointer. It goes to INT_WR.
- INT_WR: a write is held. On ready it goes to INT_VEC.
- INT_VEC: the PC takes the handler address and the flag clears. It goes to FETCH_A.
- HALT: stays in HALT.

Top module: `icc_top`

## Requirements
- R1: After reset the PC is 0, the stack pointer is SP_INIT (2047), interrupts are disabled, both strobes are low, halted is low and the subcycle code is 0.
- R2: Each fetch reads the word at the PC and increments the PC by one. A program of N straight-line instructions that ends in halt leaves the PC at N.
- R3: Load puts the operand at the effective address into the accumulator. Add adds it modulo 2^16. Store writes the accumulator to the effective address. With the indirect flag (bit 11) clear, the effective address is the address field (bits 10:0).
- R4: With bit 11 set, one extra read at the address field fetches the effective address. No extra read happens when bit 11 is clear.
- R5: Jump (opcode 4) loads the PC with its effective address, either direct or indirect.
- R6: A strobe stays asserted with a stable address until ready is seen, and each access takes exactly one ready cycle. Read and write are never asserted together.
- R7: The interrupt request is sampled only at the end of an executed instruction. It is ignored while interrupts are disabled: no stack write takes place and the stack pointer does not move.
- R8: Taking an interrupt first decrements the stack pointer. It then writes the PC of the next instruction to memory at the new stack pointer, loads the PC with VEC_ADDR (64) and disables interrupts.
- R9: Opcode 5 enables interrupts and opcode 6 disables them. Opcode 15 halts: halted goes high and no further memory access occurs.
- R10: The subcycle code reads 0 during fetch and decode, 1 during indirect, 2 during execute, check and halt, and 3 during interrupt. Each indirect or interrupt subcycle shows as one entry into code 1 or 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request level |
| mem_ready | input | 1 | Memory completes the current access this cycle |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready during a read |
| mem_addr | output | ADDR_W | Memory address (address register) |
| mem_wdata | output | DATA_W | Write data (buffer register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc_out | output | ADDR_W | Program counter |
| ac_out | output | DATA_W | Accumulator |
| sp_out | output | ADDR_W | Stack pointer |
| ien_out | output | 1 | Interrupt-enable flag |
| cycle_out | output | 2 | Current subcycle code |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Every program is run against memory latencies of zero to three wait states. The total strobe-cycle count must scale with latency, which shows that each access waits for ready, while the count of completed accesses stays fixed. Load-add-store programs are swept over operand pairs that include carry-out and wrap to zero, once with direct and once with indirect addressing. The indirect runs are told apart from the direct runs by the extra read count and the subcycle entries. Jump programs, interrupt programs with the request held high and the flag enabled or left disabled, and enable/disable programs separate a taken interrupt from an ignored one. They do so through the stack contents, the stack pointer, the return PC and the final flag value.

// File: rtl/icc_pkg.sv
package icc_pkg;

    typedef enum logic [3:0] {
        S_FETCH_A,
        S_FETCH_M,
        S_DECODE,
        S_IND_A,
        S_IND_M,
        S_EXEC_A,
        S_EXEC_RD,
        S_EXEC_WR,
        S_CHECK,
        S_INT_SAVE,
        S_INT_A,
        S_INT_WR,
        S_INT_VEC,
        S_HALT
    } state_t;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_LOAD,
        OP_STORE,
        OP_ADD,
        OP_JUMP,
        OP_EI,
        OP_DI,
        OP_HALT
    } op_t;

    localparam logic [1:0] CYC_FETCH = 2'd0;
    localparam logic [1:0] CYC_IND   = 2'd1;
    localparam logic [1:0] CYC_EXEC  = 2'd2;
    localparam logic [1:0] CYC_INT   = 2'd3;

    // micro-operations issued by the sequencer each cycle
    typedef struct packed {
        logic mar_pc;
        logic mar_ea;
        logic mar_sp;
        logic mbr_mem;
        logic mbr_pc;
        logic mbr_ac;
        logic ir_load;
        logic pc_inc;
        logic pc_ea;
        logic pc_vec;
        logic sp_dec;
        logic ac_load;
        logic ac_add;
        logic ien_set;
        logic ien_clr;
        logic rd;
        logic wr;
    } ctl_t;

endpackage

// File: rtl/icc_decode.sv
module icc_decode
    import icc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic [DATA_W-1:0] ir,
    output op_t               op,
    output logic              ind
);
    localparam int OPC_W = DATA_W - ADDR_W - 1;

    logic [OPC_W-1:0] opf;

    assign opf = ir[DATA_W-1 -: OPC_W];
    assign ind = ir[ADDR_W];

    always_comb begin
        unique case (int'(opf))
            1:       op = OP_LOAD;
            2:       op = OP_STORE;
            3:       op = OP_ADD;
            4:       op = OP_JUMP;
            5:       op = OP_EI;
            6:       op = OP_DI;
            15:      op = OP_HALT;
            default: op = OP_NOP;
        endcase
    end

endmodule

// File: rtl/icc_seq.sv
module icc_seq
    import icc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  op_t    op,
    input  logic   ind,
    input  logic   mem_ready,
    input  logic   irq,
    input  logic   ien,
    output state_t state,
    output ctl_t   ctl
);
    state_t state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_FETCH_A;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_FETCH_A:  state_n = S_FETCH_M;
            S_FETCH_M:  if (mem_ready) state_n = S_DECODE;
            S_DECODE:   state_n = ind ? S_IND_A : S_EXEC_A;
            S_IND_A:    state_n = S_IND_M;
            S_IND_M:    if (mem_ready) state_n = S_EXEC_A;
            S_EXEC_A: begin
                unique case (op)
                    OP_LOAD, OP_ADD: state_n = S_EXEC_RD;
                    OP_STORE:        state_n = S_EXEC_WR;
                    OP_HALT:         state_n = S_HALT;
                    default:         state_n = S_CHECK;
                endcase
            end
            S_EXEC_RD:  if (mem_ready) state_n = S_CHECK;
            S_EXEC_WR:  if (mem_ready) state_n = S_CHECK;
            S_CHECK:    state_n = (irq && ien) ? S_INT_SAVE : S_FETCH_A;
            S_INT_SAVE: state_n = S_INT_A;
            S_INT_A:    state_n = S_INT_WR;
            S_INT_WR:   if (mem_ready) state_n = S_INT_VEC;
            S_INT_VEC:  state_n = S_FETCH_A;
            S_HALT:     state_n = S_HALT;
            default:    state_n = S_FETCH_A;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            S_FETCH_A: begin
                ctl.mar_pc = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            S_FETCH_M: begin
                ctl.rd      = 1'b1;
                ctl.mbr_mem = mem_ready;
                ctl.ir_load = mem_ready;
            end
            S_IND_A: ctl.mar_ea = 1'b1;
            S_IND_M: begin
                ctl.rd      = 1'b1;
                ctl.mbr_mem = mem_ready;
            end
            S_EXEC_A: begin
                ctl.mar_ea  = 1'b1;
                ctl.mbr_ac  = (op == OP_STORE);
                ctl.pc_ea   = (op == OP_JUMP);
                ctl.ien_set = (op == OP_EI);
                ctl.ien_clr = (op == OP_DI);
            end
            S_EXEC_RD: begin
                ctl.rd      = 1'b1;
                ctl.mbr_mem = mem_ready;
                ctl.ac_load = mem_ready && (op == OP_LOAD);
                ctl.ac_add  = mem_ready && (op == OP_ADD);
            end
            S_EXEC_WR: ctl.wr = 1'b1;
            S_INT_SAVE: begin
                ctl.mbr_pc = 1'b1;
                ctl.sp_dec = 1'b1;
            end
            S_INT_A:  ctl.mar_sp = 1'b1;
            S_INT_WR: ctl.wr = 1'b1;
            S_INT_VEC: begin
                ctl.pc_vec  = 1'b1;
                ctl.ien_clr = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    // R6: a pending read keeps its strobe until ready
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.rd && !mem_ready) |=> ctl.rd);
    // R6: a pending write keeps its strobe until ready
    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.wr && !mem_ready) |=> ctl.wr);
    // R6: never both strobes
    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.rd && ctl.wr));

endmodule

// File: rtl/icc_dpath.sv
module icc_dpath
    import icc_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 11,
    parameter int unsigned SP_INIT  = 2047,
    parameter int unsigned VEC_ADDR = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mbr,
    output logic [DATA_W-1:0] ir,
    output logic [DATA_W-1:0] ac,
    output logic [ADDR_W-1:0] sp,
    output logic              ien
);
    localparam logic [ADDR_W-1:0] SP_RST = ADDR_W'(SP_INIT);
    localparam logic [ADDR_W-1:0] VEC    = ADDR_W'(VEC_ADDR);

    logic [ADDR_W-1:0] ea;
    assign ea = mbr[ADDR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            ac  <= '0;
            sp  <= SP_RST;
            ien <= 1'b0;
        end else begin
            if (ctl.mar_pc)      mar <= pc;
            else if (ctl.mar_ea) mar <= ea;
            else if (ctl.mar_sp) mar <= sp;

            if (ctl.mbr_mem)     mbr <= mem_rdata;
            else if (ctl.mbr_pc) mbr <= DATA_W'(pc);
            else if (ctl.mbr_ac) mbr <= ac;

            if (ctl.ir_load) ir <= mem_rdata;

            if (ctl.pc_inc)      pc <= pc + 1'b1;
            else if (ctl.pc_ea)  pc <= ea;
            else if (ctl.pc_vec) pc <= VEC;

            if (ctl.sp_dec) sp <= sp - 1'b1;

            if (ctl.ac_load)     ac <= mem_rdata;
            else if (ctl.ac_add) ac <= ac + mem_rdata;

            if (ctl.ien_set)      ien <= 1'b1;
            else if (ctl.ien_clr) ien <= 1'b0;
        end
    end

    // R8: the stack pointer moves before the address register picks it up
    p_sp_pre_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mar_sp |-> (sp != SP_RST));

endmodule

// File: rtl/icc_top.sv
module icc_top
    import icc_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 11,
    parameter int unsigned SP_INIT  = 2047,
    parameter int unsigned VEC_ADDR = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] ac_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic              ien_out,
    output logic [1:0]        cycle_out,
    output logic              halted
);
    state_t            state;
    ctl_t              ctl;
    op_t               op;
    logic              ind;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] mbr;
    logic [ADDR_W-1:0] mar;

    icc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .ir  (ir),
        .op  (op),
        .ind (ind)
    );

    icc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .ind       (ind),
        .mem_ready (mem_ready),
        .irq       (irq),
        .ien       (ien_out),
        .state     (state),
        .ctl       (ctl)
    );

    icc_dpath #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .SP_INIT  (SP_INIT),
        .VEC_ADDR (VEC_ADDR)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .pc        (pc_out),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir),
        .ac        (ac_out),
        .sp        (sp_out),
        .ien       (ien_out)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign mem_rd    = ctl.rd;
    assign mem_wr    = ctl.wr;
    assign halted    = (state == S_HALT);

    always_comb begin
        unique case (state)
            S_FETCH_A, S_FETCH_M, S_DECODE:        cycle_out = CYC_FETCH;
            S_IND_A, S_IND_M:                      cycle_out = CYC_IND;
            S_INT_SAVE, S_INT_A, S_INT_WR, S_INT_VEC: cycle_out = CYC_INT;
            default:                               cycle_out = CYC_EXEC;
        endcase
    end

    // R2: the PC advances by one when a fetch is set up
    p_pc_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH_A) |=> (pc_out == $past(pc_out) + 1'b1));
    // R6: the address holds while a strobe waits
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_ready) |=> $stable(mem_addr));
    // R4: the indirect read goes to the instruction's address field
    p_ind_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_out == CYC_IND && mem_rd) |-> (mem_addr == ir[ADDR_W-1:0]));
    // R3: a direct operand access uses the address field
    p_ea_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_out == CYC_EXEC && (mem_rd || mem_wr) && !ir[ADDR_W])
        |-> (mem_addr == ir[ADDR_W-1:0]));
    // R7: an interrupt subcycle starts only on an enabled request
    p_int_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cycle_out == CYC_INT) |-> ($past(irq) && $past(ien_out)));
    // R8: the saved word is the PC, written at the stack pointer
    p_save_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_out == CYC_INT && mem_wr)
        |-> (mem_wdata == DATA_W'(pc_out) && mem_addr == sp_out));
    // R8: vectoring loads the handler address and masks interrupts
    p_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_INT_VEC) |=> (pc_out == ADDR_W'(VEC_ADDR) && !ien_out));
    // R9: a halted machine stays halted and quiet
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_rd && !mem_wr));

endmodule

// File: tb/test_icc_top.sv
module test_icc_top;
    localparam int DW = 16;
    localparam int AW = 11;
    localparam logic [AW-1:0] SP0 = 11'h7FF;
    localparam logic [AW-1:0] VEC = 11'h040;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          irq;
    logic          mem_ready;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rd;
    logic          mem_wr;
    logic [AW-1:0] pc_out;
    logic [DW-1:0] ac_out;
    logic [AW-1:0] sp_out;
    logic          ien_out;
    logic [1:0]    cycle_out;
    logic          halted;

    icc_top i_icc_top (
        .clk(clk), .rst_n(rst_n), .irq(irq), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_out(pc_out), .ac_out(ac_out),
        .sp_out(sp_out), .ien_out(ien_out), .cycle_out(cycle_out),
        .halted(halted)
    );

    logic [DW-1:0] mem [0:2047];
    int lat;
    int wcnt;
    int rd_n, wr_n, strobe_n, both_n, ind_n, int_n;
    logic [1:0] cyc_prev;
    int total = 0;
    int bad = 0;

    assign mem_ready = (mem_rd || mem_wr) && (wcnt == lat);
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 0; rd_n <= 0; wr_n <= 0; strobe_n <= 0;
            both_n <= 0; ind_n <= 0; int_n <= 0; cyc_prev <= 2'd0;
        end else begin
            if ((mem_rd || mem_wr) && !mem_ready) wcnt <= wcnt + 1;
            else wcnt <= 0;
            if (mem_rd || mem_wr) strobe_n <= strobe_n + 1;
            if (mem_rd && mem_wr) both_n <= both_n + 1;
            if (mem_rd && mem_ready) rd_n <= rd_n + 1;
            if (mem_wr && mem_ready) begin
                wr_n <= wr_n + 1;
                mem[mem_addr] <= mem_wdata;
            end
            cyc_prev <= cycle_out;
            if (cycle_out == 2'd1 && cyc_prev != 2'd1) ind_n <= ind_n + 1;
            if (cycle_out == 2'd3 && cyc_prev != 2'd3) int_n <= int_n + 1;
        end
    end

    function automatic logic [DW-1:0] ins(int opc, int ind, int addr);
        return {opc[3:0], ind[0], addr[10:0]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start(int lat_v, logic irq_v);
        rst_n = 1'b0;
        irq   = irq_v;
        lat   = lat_v;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 2048; i++) mem[i] <= '0;
        @(negedge clk);
    endtask

    task automatic go();
        int n;
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!halted) chk("watchdog run", 32'd0, 32'd1);
        repeat (2) @(negedge clk);
    endtask

    task automatic halt_quiet(string tag);
        int r0, w0;
        r0 = rd_n; w0 = wr_n;
        repeat (10) @(negedge clk);
        chk({tag, " R9 halted stays"}, 32'(halted), 32'd1);
        chk({tag, " R9 no access after halt"}, 32'(rd_n + wr_n), 32'(r0 + w0));
    endtask

    initial begin
        rst_n = 1'b0;
        irq   = 1'b0;
        lat   = 0;
        start(0, 1'b0);
        // R1: reset values
        chk("R1 pc", 32'(pc_out), 32'd0);
        chk("R1 sp", 32'(sp_out), 32'(SP0));
        chk("R1 ien", 32'(ien_out), 32'd0);
        chk("R1 strobes", 32'({mem_rd, mem_wr}), 32'd0);
        chk("R1 halted", 32'(halted), 32'd0);
        chk("R1 cycle", 32'(cycle_out), 32'd0);

        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < 4; k++) begin
                logic [DW-1:0] a, b, s;
                case (k)
                    0: begin a = 16'd3;    b = 16'd4;    end
                    1: begin a = 16'hFFFF; b = 16'h0001; end
                    2: begin a = 16'h8000; b = 16'h8000; end
                    default: begin a = 16'h1234; b = 16'h4321; end
                endcase
                s = a + b;

                // direct load / add / store
                start(l, 1'b0);
                mem[0] <= ins(1, 0, 100);
                mem[1] <= ins(3, 0, 101);
                mem[2] <= ins(2, 0, 102);
                mem[3] <= ins(15, 0, 0);
                mem[100] <= a;
                mem[101] <= b;
                go();
                chk("R3 direct store", 32'(mem[102]), 32'(s));
                chk("R3 direct ac", 32'(ac_out), 32'(s));
                chk("R2 pc after 4 words", 32'(pc_out), 32'd4);
                chk("R6 strobe cycles direct", 32'(strobe_n), 32'(7 * (l + 1)));
                chk("R6 read count direct", 32'(rd_n), 32'd6);
                chk("R6 write count direct", 32'(wr_n), 32'd1);
                chk("R6 no double strobe", 32'(both_n), 32'd0);
                chk("R4 no indirect when bit 11 clear", 32'(ind_n), 32'd0);
                chk("R10 no interrupt code", 32'(int_n), 32'd0);
                if (k == 0) halt_quiet("direct");

                // indirect load / add / store
                start(l, 1'b0);
                mem[0] <= ins(1, 1, 200);
                mem[1] <= ins(3, 1, 201);
                mem[2] <= ins(2, 1, 202);
                mem[3] <= ins(15, 0, 0);
                mem[200] <= 16'd300;
                mem[201] <= 16'd301;
                mem[202] <= 16'd302;
                mem[300] <= a;
                mem[301] <= b;
                go();
                chk("R4 indirect store", 32'(mem[302]), 32'(s));
                chk("R4 pointer untouched", 32'(mem[202]), 32'd302);
                chk("R4 indirect ac", 32'(ac_out), 32'(s));
                chk("R4 read count indirect", 32'(rd_n), 32'd9);
                chk("R10 indirect entries", 32'(ind_n), 32'd3);
                chk("R6 strobe cycles indirect", 32'(strobe_n), 32'(10 * (l + 1)));
            end

            // R5: direct and indirect jump
            start(l, 1'b0);
            mem[0]  <= ins(4, 0, 10);
            mem[1]  <= ins(2, 0, 102);
            mem[10] <= ins(1, 0, 100);
            mem[11] <= ins(4, 1, 20);
            mem[12] <= ins(2, 0, 103);
            mem[20] <= 16'd30;
            mem[30] <= ins(15, 0, 0);
            mem[100] <= 16'h5A5A;
            go();
            chk("R5 jump target pc", 32'(pc_out), 32'd31);
            chk("R5 ac via jump", 32'(ac_out), 32'h5A5A);
            chk("R5 skipped store", 32'(mem[102]), 32'd0);
            chk("R5 skipped store after indirect jump", 32'(mem[103]), 32'd0);

            // R7/R8: enabled interrupt taken after EI
            start(l, 1'b1);
            mem[0]  <= ins(5, 0, 0);
            mem[1]  <= ins(0, 0, 0);
            mem[2]  <= ins(15, 0, 0);
            mem[64] <= ins(1, 0, 100);
            mem[65] <= ins(15, 0, 0);
            mem[100] <= 16'hC0DE;
            go();
            chk("R8 saved return pc", 32'(mem[SP0 - 1'b1]), 32'd1);
            chk("R8 slot above untouched", 32'(mem[SP0]), 32'd0);
            chk("R8 sp decremented", 32'(sp_out), 32'(SP0 - 1'b1));
            chk("R8 ien cleared", 32'(ien_out), 32'd0);
            chk("R8 handler ran", 32'(ac_out), 32'hC0DE);
            chk("R8 pc in handler", 32'(pc_out), 32'(VEC + 2));
            chk("R10 interrupt entries", 32'(int_n), 32'd1);
            chk("R8 one write", 32'(wr_n), 32'd1);
            chk("R6 strobe cycles interrupt", 32'(strobe_n), 32'(5 * (l + 1)));

            // R7: request ignored while disabled
            start(l, 1'b1);
            mem[0] <= ins(0, 0, 0);
            mem[1] <= ins(1, 0, 100);
            mem[2] <= ins(15, 0, 0);
            mem[100] <= 16'h0042;
            mem[SP0 - 1'b1] <= 16'hDEAD;
            go();
            chk("R7 stack untouched", 32'(mem[SP0 - 1'b1]), 32'hDEAD);
            chk("R7 sp unchanged", 32'(sp_out), 32'(SP0));
            chk("R7 pc straight line", 32'(pc_out), 32'd3);
            chk("R7 no interrupt entry", 32'(int_n), 32'd0);
            chk("R7 no write", 32'(wr_n), 32'd0);

            // R9: enable then disable
            start(l, 1'b0);
            mem[0] <= ins(5, 0, 0);
            mem[1] <= ins(15, 0, 0);
            go();
            chk("R9 EI sets flag", 32'(ien_out), 32'd1);
            start(l, 1'b0);
            mem[0] <= ins(5, 0, 0);
            mem[1] <= ins(6, 0, 0);
            mem[2] <= ins(15, 0, 0);
            go();
            chk("R9 DI clears flag", 32'(ien_out), 32'd0);
            chk("R9 pc after DI program", 32'(pc_out), 32'd3);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1900000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule